// File: doc/BRIEF.md
# Threshold DMA Sector Buffer

This block sits between a disk byte path and a DMA host port. It holds sector data for one command at a time. On a disk read the disk side fills the buffer one byte per strobe and the host drains it through DMA request/acknowledge cycles. On a disk write the host fills the buffer and each disk strobe takes one byte out. The direction is captured when the command enters its execution phase, and the buffer is emptied at that moment.

After reset, and whenever the enable input is low, the buffer holds a single byte, like a plain data register. With the enable high during execution it holds up to `DEPTH` bytes, and a 4-bit threshold sets how early the DMA request comes. On reads the request follows occupancy. On writes it follows free space. A larger threshold gives the host more time before data is lost.

A read overrun is a disk byte with no room left. A write underrun is a disk strobe with nothing buffered. Either one stops the transfer and raises a sticky termination flag. After a read overrun the bytes already held can still be drained, and a drained flag then shows that results may follow. After a write underrun the block sends zero bytes to the disk until the sector ends. It then raises a flag asking for a valid CRC to be appended.

Top module: `dma_sector_fifo`

## Requirements
- R1: After reset `dma_req`, `level`, `xfer_term`, `overrun`, `underrun`, `pad_active`, `crc_req` and `drained` are all 0.
- R2: With `cfg_fifo_en`=0 the buffer holds at most one byte. On a read, a second disk strobe before the host acknowledge is an overrun.
- R3: With `cfg_fifo_en`=1 the buffer holds `DEPTH` (16) bytes. On a read, the disk byte that arrives while 16 are held is an overrun and is dropped.
- R4: On a read, `dma_req` is 1 while `level` >= the effective threshold. The effective threshold is `cfg_thresh`, with 0 read as 1, and it is 1 when the buffer is disabled.
- R5: On a write, `dma_req` is 1 while free space (capacity − `level`) >= the effective threshold and no termination is flagged.
- R6: An `exec_start` pulse empties the buffer and clears `xfer_term`, `overrun`, `underrun`, `pad_active`, `crc_req` and `drained`. Disk strobes and acknowledges in that cycle are ignored.
- R7: While `exec_active` is 0, `dma_req` is 0 and disk strobes and acknowledges do not change `level`.
- R8: A read overrun sets `overrun` and `xfer_term`. Afterwards further disk bytes are ignored, `dma_req` stays 1 while bytes remain, and `drained` becomes 1 once `level` is 0.
- R9: A write underrun sets `underrun` and `xfer_term` and drives `disk_wr_data`=0x00 on that strobe and on every later strobe up to the last byte of the sector (`sector_len` bytes, counted from `exec_start`). `crc_req` becomes 1 when the last byte of the sector is sent, and host acknowledges are ignored after the underrun.
- R10: Bytes leave the buffer in the order they entered. On a write, `disk_wr_data` is loaded with the oldest byte on each disk strobe.
- R11: The transfer direction is taken from `xfer_dir` (1 = disk read toward host, 0 = disk write) at `exec_start` and ignored afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fifo_en | input | 1 | 1 = multi-byte buffering, 0 = single-byte register |
| cfg_thresh | input | 4 | DMA request threshold |
| sector_len | input | 10 | Sector length in bytes (>=1) |
| xfer_dir | input | 1 | Direction sampled at exec_start (1 read, 0 write) |
| exec_start | input | 1 | Pulse: execution phase begins, flush |
| exec_active | input | 1 | Execution phase in progress |
| disk_strobe | input | 1 | One disk byte slot |
| disk_rd_data | input | 8 | Byte from disk (read) |
| disk_wr_data | output | 8 | Byte to disk (write), updated on each strobe |
| dma_req | output | 1 | DMA request to host |
| dma_ack | input | 1 | DMA acknowledge, one byte per cycle |
| host_wr_data | input | 8 | Host byte (write) |
| host_rd_data | output | 8 | Oldest buffered byte (read) |
| level | output | 5 | Bytes held |
| xfer_term | output | 1 | Transfer terminated |
| overrun | output | 1 | Read overrun seen |
| underrun | output | 1 | Write underrun seen |
| pad_active | output | 1 | Zero padding in progress |
| crc_req | output | 1 | Sector padded, valid CRC must follow |
| drained | output | 1 | Read terminated and buffer empty |

## Verification
The hardest state to reach from the ports is the end of zero padding after a write underrun, because it depends on where the underrun falls within the sector. The bench sets a short sector. It loads two bytes by acknowledge, then strobes the disk past them so that the underrun lands mid-sector. It checks the zero bytes, the ignored acknowledges and the exact strobe on which `crc_req` rises. The drain-after-overrun path is reached by filling all 16 entries and sending one more disk byte.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] lvl_q, lvl_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    lvl_d    = lvl_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      lvl_d    = '0;
    end else begin
      if (push) wr_ptr_d = (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_d = (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      case ({push, pop})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      lvl_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      lvl_q    <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr_q] <= din;
  end

  assign dout  = mem[rd_ptr_q];
  assign level = lvl_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH)); // R3
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (lvl_q != '0)); // R10
endmodule

// File: rtl/sfifo_req_gen.sv
module sfifo_req_gen #(
  parameter int LW  = 5,
  parameter int THW = 4
) (
  input  logic           active,
  input  logic           dir_rd,
  input  logic           term,
  input  logic [LW-1:0]  cap,
  input  logic [LW-1:0]  level,
  input  logic           fifo_en,
  input  logic [THW-1:0] thresh,
  output logic           dma_req
);
  logic [LW-1:0] thr_eff;
  logic [LW-1:0] free_sp;

  always_comb begin
    if (!fifo_en || thresh == '0) thr_eff = LW'(1);
    else                          thr_eff = LW'(thresh);
    free_sp = cap - level;
    if (!active)     dma_req = 1'b0;
    else if (dir_rd) dma_req = term ? (level != '0) : (level >= thr_eff);
    else             dma_req = !term && (free_sp >= thr_eff);
  end
endmodule

// File: rtl/sfifo_pad_seq.sv
module sfifo_pad_seq #(
  parameter int SLW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           strobe_wr,
  input  logic           und_hit,
  input  logic [SLW-1:0] sector_len,
  output logic           pad_active,
  output logic           crc_req
);
  logic [SLW-1:0] idx_q, idx_d;
  logic           pad_q, pad_d, crc_q, crc_d;
  logic           last_byte;

  assign last_byte = (idx_q == sector_len - 1'b1);

  always_comb begin
    idx_d = idx_q;
    pad_d = pad_q;
    crc_d = crc_q;
    if (flush) begin
      idx_d = '0;
      pad_d = 1'b0;
      crc_d = 1'b0;
    end else if (strobe_wr) begin
      idx_d = last_byte ? '0 : idx_q + 1'b1;
      if (und_hit) begin
        pad_d = !last_byte;
        crc_d = last_byte;
      end else if (pad_q && last_byte) begin
        pad_d = 1'b0;
        crc_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      pad_q <= 1'b0;
      crc_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      pad_q <= pad_d;
      crc_q <= crc_d;
    end
  end

  assign pad_active = pad_q;
  assign crc_req    = crc_q;

  AST_CRC_AFTER_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_q) |-> ($past(pad_q) || $past(und_hit))); // R9
  AST_PAD_CRC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pad_q && crc_q)); // R9
endmodule

// File: rtl/dma_sector_fifo.sv
module dma_sector_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int THW   = 4,
  parameter int SLW   = 10,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_fifo_en,
  input  logic [THW-1:0] cfg_thresh,
  input  logic [SLW-1:0] sector_len,
  input  logic           xfer_dir,
  input  logic           exec_start,
  input  logic           exec_active,
  input  logic           disk_strobe,
  input  logic [DW-1:0]  disk_rd_data,
  output logic [DW-1:0]  disk_wr_data,
  output logic           dma_req,
  input  logic           dma_ack,
  input  logic [DW-1:0]  host_wr_data,
  output logic [DW-1:0]  host_rd_data,
  output logic [LW-1:0]  level,
  output logic           xfer_term,
  output logic           overrun,
  output logic           underrun,
  output logic           pad_active,
  output logic           crc_req,
  output logic           drained
);
  import sfifo_pkg::*;

  xfer_dir_e     dir_q, dir_d;
  logic          ovr_q, ovr_d, und_q, und_d;
  logic [DW-1:0] dwr_q, dwr_d;
  logic          run, dir_rd, en_eff, term;
  logic [LW-1:0] cap, lvl;
  logic          push, pop, ovr_hit, und_hit, strobe_wr;
  logic [DW-1:0] push_data, head;

  assign run    = exec_active && !exec_start;
  assign dir_rd = (dir_q == DIR_READ);
  assign en_eff = cfg_fifo_en && exec_active;
  assign cap    = en_eff ? LW'(DEPTH) : LW'(1);
  assign term   = ovr_q || und_q;

  always_comb begin
    push      = 1'b0;
    pop       = 1'b0;
    ovr_hit   = 1'b0;
    und_hit   = 1'b0;
    push_data = host_wr_data;
    if (run && dir_rd) begin
      push_data = disk_rd_data;
      push      = disk_strobe && !term && (lvl < cap);
      ovr_hit   = disk_strobe && !term && (lvl >= cap);
      pop       = dma_ack && (lvl != '0);
    end else if (run) begin
      push      = dma_ack && !term && (lvl < cap);
      pop       = disk_strobe && !term && (lvl != '0);
      und_hit   = disk_strobe && !term && (lvl == '0);
    end
  end

  assign strobe_wr = run && !dir_rd && disk_strobe;

  always_comb begin
    dir_d = dir_q;
    ovr_d = ovr_q;
    und_d = und_q;
    dwr_d = dwr_q;
    if (exec_start) begin
      dir_d = xfer_dir ? DIR_READ : DIR_WRITE;
      ovr_d = 1'b0;
      und_d = 1'b0;
    end else begin
      if (ovr_hit) ovr_d = 1'b1;
      if (und_hit) und_d = 1'b1;
      if (strobe_wr) dwr_d = pop ? head : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_WRITE;
      ovr_q <= 1'b0;
      und_q <= 1'b0;
      dwr_q <= '0;
    end else begin
      dir_q <= dir_d;
      ovr_q <= ovr_d;
      und_q <= und_d;
      dwr_q <= dwr_d;
    end
  end

  sfifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(exec_start),
    .push(push), .pop(pop), .din(push_data), .dout(head), .level(lvl)
  );

  sfifo_req_gen #(.LW(LW), .THW(THW)) u_req (
    .active(exec_active), .dir_rd(dir_rd), .term(term), .cap(cap),
    .level(lvl), .fifo_en(en_eff), .thresh(cfg_thresh), .dma_req(dma_req)
  );

  sfifo_pad_seq #(.SLW(SLW)) u_pad (
    .clk(clk), .rst_n(rst_n), .flush(exec_start), .strobe_wr(strobe_wr),
    .und_hit(und_hit), .sector_len(sector_len),
    .pad_active(pad_active), .crc_req(crc_req)
  );

  assign disk_wr_data = dwr_q;
  assign host_rd_data = head;
  assign level        = lvl;
  assign xfer_term    = term;
  assign overrun      = ovr_q;
  assign underrun     = und_q;
  assign drained      = ovr_q && dir_rd && (lvl == '0);

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> (level == '0) && !xfer_term && !crc_req); // R6
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_active |-> !dma_req); // R7
  AST_TERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_term && !exec_start) |=> xfer_term); // R8
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_active && disk_strobe && exec_active && !exec_start) |=> (disk_wr_data == '0)); // R9
  AST_SINGLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fifo_en && $stable(cfg_fifo_en) && !exec_start && $past(!cfg_fifo_en)) |-> (level <= LW'(1))); // R2
endmodule

// File: tb/tb_dma_sector_fifo.sv
module tb_dma_sector_fifo;
  logic       clk, rst_n;
  logic       cfg_fifo_en;
  logic [3:0] cfg_thresh;
  logic [9:0] sector_len;
  logic       xfer_dir, exec_start, exec_active, disk_strobe, dma_ack;
  logic [7:0] disk_rd_data, host_wr_data, disk_wr_data, host_rd_data;
  logic       dma_req, xfer_term, overrun, underrun, pad_active, crc_req, drained;
  logic [4:0] level;
  int n_chk, n_fail;

  dma_sector_fifo dut (
    .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_thresh(cfg_thresh),
    .sector_len(sector_len), .xfer_dir(xfer_dir), .exec_start(exec_start),
    .exec_active(exec_active), .disk_strobe(disk_strobe), .disk_rd_data(disk_rd_data),
    .disk_wr_data(disk_wr_data), .dma_req(dma_req), .dma_ack(dma_ack),
    .host_wr_data(host_wr_data), .host_rd_data(host_rd_data), .level(level),
    .xfer_term(xfer_term), .overrun(overrun), .underrun(underrun),
    .pad_active(pad_active), .crc_req(crc_req), .drained(drained)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic start(input logic dir);
    @(negedge clk);
    xfer_dir = dir; exec_start = 1'b1; exec_active = 1'b1;
    @(negedge clk);
    exec_start = 1'b0;
  endtask

  task automatic dstrobe(input logic [7:0] b);
    @(negedge clk);
    disk_strobe = 1'b1; disk_rd_data = b;
    @(negedge clk);
    disk_strobe = 1'b0;
  endtask

  task automatic hack(input logic [7:0] b);
    @(negedge clk);
    dma_ack = 1'b1; host_wr_data = b;
    @(negedge clk);
    dma_ack = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 dma_req", dma_req, 0);
    check("R1 level", level, 0);
    check("R1 flags", {xfer_term, overrun, underrun, pad_active, crc_req, drained}, 0);
  endtask

  task automatic t_idle;
    exec_active = 1'b0;
    dstrobe(8'h33);
    hack(8'h44);
    check("R7 level idle", level, 0);
    check("R7 dma_req idle", dma_req, 0);
  endtask

  task automatic t_single;
    cfg_fifo_en = 1'b0;
    start(1'b1);
    dstrobe(8'hA5);
    check("R2 level one", level, 1);
    check("R2 req", dma_req, 1);
    check("R2 head", host_rd_data, 8'hA5);
    dstrobe(8'h5A);
    check("R2 overrun", overrun, 1);
    check("R2 term", xfer_term, 1);
    check("R2 level held", level, 1);
    check("R2 head kept", host_rd_data, 8'hA5);
    hack(8'h00);
    check("R8 drained", drained, 1);
    check("R8 req off", dma_req, 0);
  endtask

  task automatic t_read_thresh;
    cfg_fifo_en = 1'b1; cfg_thresh = 4'd4;
    start(1'b1);
    for (int i = 0; i < 3; i++) dstrobe(8'(8'h10 + i));
    check("R4 below thr", dma_req, 0);
    dstrobe(8'h13);
    check("R4 at thr", dma_req, 1);
    for (int i = 4; i < 16; i++) dstrobe(8'(8'h10 + i));
    check("R3 full", level, 16);
    check("R3 no overrun yet", overrun, 0);
    dstrobe(8'hEE);
    check("R3 overrun", overrun, 1);
    check("R3 level kept", level, 16);
    dstrobe(8'hEF);
    check("R8 ignored after term", level, 16);
    for (int i = 0; i < 16; i++) begin
      check("R8 req while bytes", dma_req, 1);
      check("R10 order", host_rd_data, 8'h10 + i);
      hack(8'h00);
    end
    check("R8 drained", drained, 1);
    check("R8 level empty", level, 0);
  endtask

  task automatic t_thr_zero;
    cfg_thresh = 4'd0;
    start(1'b1);
    check("R6 flushed", level, 0);
    check("R6 flags clear", {xfer_term, overrun, drained}, 0);
    dstrobe(8'h01);
    check("R4 thr zero", dma_req, 1);
  endtask

  task automatic t_write_req;
    cfg_thresh = 4'd8;
    start(1'b0);
    check("R5 empty req", dma_req, 1);
    for (int i = 0; i < 8; i++) hack(8'(8'h80 + i));
    check("R5 free eq thr", dma_req, 1);
    hack(8'h88);
    check("R5 free below", dma_req, 0);
    dstrobe(8'h00);
    check("R10 first out", disk_wr_data, 8'h80);
    check("R5 free back", dma_req, 1);
  endtask

  task automatic t_underrun;
    cfg_thresh = 4'd1; sector_len = 10'd6;
    start(1'b0);
    hack(8'h11);
    hack(8'h22);
    dstrobe(8'h00);
    check("R10 byte1", disk_wr_data, 8'h11);
    dstrobe(8'h00);
    check("R10 byte2", disk_wr_data, 8'h22);
    dstrobe(8'h00);
    check("R9 underrun", underrun, 1);
    check("R9 term", xfer_term, 1);
    check("R9 pad on", pad_active, 1);
    check("R9 zero", disk_wr_data, 0);
    check("R9 req off", dma_req, 0);
    hack(8'h77);
    check("R9 ack ignored", level, 0);
    dstrobe(8'h00);
    check("R9 zero 4", disk_wr_data, 0);
    check("R9 no crc yet", crc_req, 0);
    dstrobe(8'h00);
    check("R9 no crc 5", crc_req, 0);
    dstrobe(8'h00);
    check("R9 crc at end", crc_req, 1);
    check("R9 pad off", pad_active, 0);
    start(1'b0);
    check("R6 crc cleared", crc_req, 0);
    check("R6 underrun cleared", underrun, 0);
  endtask

  task automatic t_dir_latch;
    cfg_thresh = 4'd1;
    start(1'b1);
    @(negedge clk);
    xfer_dir = 1'b0;
    dstrobe(8'h5C);
    check("R11 read kept", level, 1);
    check("R11 head", host_rd_data, 8'h5C);
    check("R11 no underrun", underrun, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cfg_fifo_en = 1'b0; cfg_thresh = 4'd0; sector_len = 10'd512;
    xfer_dir = 1'b0; exec_start = 1'b0; exec_active = 1'b0; disk_strobe = 1'b0;
    dma_ack = 1'b0; disk_rd_data = '0; host_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_single();
    t_read_thresh();
    t_thr_zero();
    t_write_req();
    t_underrun();
    t_dir_latch();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule